// File: doc/BRIEF.md
# Machine Control Register with Coprocessor Trap Evaluation

This block holds the processor's machine-control word and its page-directory base address. The control word has six defined flags: paging enable, extension type, task switched, emulate coprocessor, monitor coprocessor and protection enable. Every other bit reads as zero. Software can change the word in two ways. The first is a full 32-bit load. The second is a legacy 16-bit load, which touches only the low half. The legacy load leaves the extension-type flag alone, and it can set protection enable but can never clear it.

A task-switch strobe does two things. It forces the task-switched flag to one, and it presents the incoming task's directory base. For each decoded coprocessor opcode, the block decides whether a coprocessor-not-available trap must be raised. An escape opcode and a wait opcode use different conditions. When a directory-base load must invalidate the translation cache, the block issues a flush pulse. The paging unit, the trap handler and the task-switch sequencing live elsewhere. They talk to this block only through strobes and the trap and flush pulses.

Top module: `mcr_trap_unit`

## Requirements
- R1: On synchronous reset, the paging (bit 31), task-switched (bit 3), emulate (bit 2), monitor (bit 1) and protection (bit 0) flags clear. The extension-type flag (bit 4) takes the level of `err_level_i` during reset. The directory base, `trap_o` and `flush_o` are 0.
- R2: A full load (`full_wr_i`) copies bits 31, 4, 3, 2, 1 and 0 of `wr_data_i` into the control word on the next clock. All other bits of `ctrl_o` read 0. A full load can clear protection enable.
- R3: A legacy load (`legacy_wr_i` without `full_wr_i`) copies bits 3..1 of `wr_data_i`. It ORs bit 0 into protection enable. It leaves bits 31 and 4 unchanged. When both loads are strobed together, the full load wins.
- R4: `tswitch_i` sets the task-switched flag (bit 3) on the next clock. This takes priority over a load in the same cycle that writes it to 0.
- R5: An escape opcode (`op_valid_i` with `op_is_wait_i`=0) raises `trap_o` for exactly one cycle after the strobe when emulate or task-switched is 1. While `trap_o` is 1, `trap_vec_o` is 7; otherwise it is 0.
- R6: A wait opcode (`op_is_wait_i`=1) ignores the emulate flag. It traps only when monitor and task-switched are both 1.
- R7: The directory base drops bits 11..0 on every write, so they always read 0.
- R8: An explicit directory load (`dir_wr_i`) pulses `flush_o` for one cycle after the strobe, even when the value is unchanged.
- R9: A task-switch directory load pulses `flush_o` only when its masked value differs from the stored base. If `dir_wr_i` is strobed in the same cycle, the explicit load wins.
- R10: A trap decision uses the control word as it was before any load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_level_i | input | 1 | Error input level, captured as extension type during reset |
| full_wr_i | input | 1 | Full 32-bit control-word load strobe |
| legacy_wr_i | input | 1 | Legacy 16-bit control-word load strobe |
| wr_data_i | input | 32 | Control-word load data |
| dir_wr_i | input | 1 | Explicit directory-base load strobe |
| dir_data_i | input | 32 | Explicit directory-base data |
| tswitch_i | input | 1 | Task-switch strobe |
| ts_dir_data_i | input | 32 | Directory base of the incoming task |
| op_valid_i | input | 1 | Decoded coprocessor opcode strobe |
| op_is_wait_i | input | 1 | 1 = wait opcode, 0 = escape opcode |
| ctrl_o | output | 32 | Control word |
| dir_base_o | output | 32 | Directory base, low 12 bits zero |
| trap_o | output | 1 | Coprocessor-not-available trap pulse |
| trap_vec_o | output | 8 | Trap vector, 7 while `trap_o` is 1 |
| flush_o | output | 1 | Translation-cache flush pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit directory base with a 12-bit page offset, and trap vector 7. These values make every combination of the emulate, monitor and task-switched flags reachable for both opcode classes, a sweep of sixteen cases. Around that sweep, the bench checks load priority, the stickiness of protection enable, and flush behaviour for both changed and unchanged directory values.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int CW_W   = 32;
  localparam int PG_BIT = 31;
  localparam int ET_BIT = 4;
  localparam int TS_BIT = 3;
  localparam int EM_BIT = 2;
  localparam int MP_BIT = 1;
  localparam int PE_BIT = 0;

  typedef struct packed {
    logic pg;
    logic et;
    logic ts;
    logic em;
    logic mp;
    logic pe;
  } mcr_t;

  function automatic logic [CW_W-1:0] mcr_pack(input mcr_t f);
    logic [CW_W-1:0] w;
    w = '0;
    w[PG_BIT] = f.pg;
    w[ET_BIT] = f.et;
    w[TS_BIT] = f.ts;
    w[EM_BIT] = f.em;
    w[MP_BIT] = f.mp;
    w[PE_BIT] = f.pe;
    return w;
  endfunction
endpackage

// File: rtl/mcr_ctrl_reg.sv
module mcr_ctrl_reg
  import mcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            err_level_i,
  input  logic            full_wr_i,
  input  logic            legacy_wr_i,
  input  logic [CW_W-1:0] wr_data_i,
  input  logic            ts_set_i,
  output mcr_t            q_o
);
  mcr_t nxt;

  always_comb begin
    nxt = q_o;
    if (full_wr_i) begin
      nxt.pg = wr_data_i[PG_BIT];
      nxt.et = wr_data_i[ET_BIT];
      nxt.ts = wr_data_i[TS_BIT];
      nxt.em = wr_data_i[EM_BIT];
      nxt.mp = wr_data_i[MP_BIT];
      nxt.pe = wr_data_i[PE_BIT];
    end else if (legacy_wr_i) begin
      nxt.ts = wr_data_i[TS_BIT];
      nxt.em = wr_data_i[EM_BIT];
      nxt.mp = wr_data_i[MP_BIT];
      nxt.pe = q_o.pe | wr_data_i[PE_BIT];
    end
    if (ts_set_i) nxt.ts = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o    <= '0;
      q_o.et <= err_level_i;
    end else begin
      q_o <= nxt;
    end
  end
endmodule

// File: rtl/mcr_dir_reg.sv
module mcr_dir_reg #(
  parameter int DIR_W     = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_wr_i,
  input  logic [DIR_W-1:0] dir_data_i,
  input  logic             ts_ld_i,
  input  logic [DIR_W-1:0] ts_data_i,
  output logic [DIR_W-1:0] dir_o,
  output logic             flush_o
);
  localparam int HI_W = DIR_W - PAGE_BITS;

  logic [HI_W-1:0] hi_q;
  logic [HI_W-1:0] ts_hi;

  assign ts_hi = ts_data_i[DIR_W-1:PAGE_BITS];
  assign dir_o = {hi_q, {PAGE_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      flush_o <= 1'b0;
    end else if (dir_wr_i) begin
      hi_q    <= dir_data_i[DIR_W-1:PAGE_BITS];
      flush_o <= 1'b1;
    end else if (ts_ld_i) begin
      hi_q    <= ts_hi;
      flush_o <= (ts_hi != hi_q);
    end else begin
      flush_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mcr_trap_eval.sv
module mcr_trap_eval #(
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid_i,
  input  logic             op_is_wait_i,
  input  logic             em_i,
  input  logic             mp_i,
  input  logic             ts_i,
  output logic             trap_o,
  output logic [VEC_W-1:0] vec_o
);
  logic hit;

  always_comb begin
    if (op_is_wait_i) hit = mp_i & ts_i;
    else              hit = em_i | ts_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      trap_o <= op_valid_i & hit;
      vec_o  <= (op_valid_i & hit) ? VEC_W'(TRAP_VEC) : '0;
    end
  end
endmodule

// File: rtl/mcr_trap_unit.sv
module mcr_trap_unit
  import mcr_pkg::*;
#(
  parameter int DIR_W     = 32,
  parameter int PAGE_BITS = 12,
  parameter int VEC_W     = 8,
  parameter int TRAP_VEC  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_level_i,
  input  logic             full_wr_i,
  input  logic             legacy_wr_i,
  input  logic [CW_W-1:0]  wr_data_i,
  input  logic             dir_wr_i,
  input  logic [DIR_W-1:0] dir_data_i,
  input  logic             tswitch_i,
  input  logic [DIR_W-1:0] ts_dir_data_i,
  input  logic             op_valid_i,
  input  logic             op_is_wait_i,
  output logic [CW_W-1:0]  ctrl_o,
  output logic [DIR_W-1:0] dir_base_o,
  output logic             trap_o,
  output logic [VEC_W-1:0] trap_vec_o,
  output logic             flush_o
);
  mcr_t cw;

  mcr_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .err_level_i (err_level_i),
    .full_wr_i   (full_wr_i),
    .legacy_wr_i (legacy_wr_i),
    .wr_data_i   (wr_data_i),
    .ts_set_i    (tswitch_i),
    .q_o         (cw)
  );

  mcr_dir_reg #(.DIR_W(DIR_W), .PAGE_BITS(PAGE_BITS)) u_dir (
    .clk        (clk),
    .rst        (rst),
    .dir_wr_i   (dir_wr_i),
    .dir_data_i (dir_data_i),
    .ts_ld_i    (tswitch_i),
    .ts_data_i  (ts_dir_data_i),
    .dir_o      (dir_base_o),
    .flush_o    (flush_o)
  );

  mcr_trap_eval #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_trap (
    .clk          (clk),
    .rst          (rst),
    .op_valid_i   (op_valid_i),
    .op_is_wait_i (op_is_wait_i),
    .em_i         (cw.em),
    .mp_i         (cw.mp),
    .ts_i         (cw.ts),
    .trap_o       (trap_o),
    .vec_o        (trap_vec_o)
  );

  assign ctrl_o = mcr_pack(cw);
endmodule

// File: rtl/mcr_trap_chk.sv
module mcr_trap_chk #(
  parameter int DIR_W     = 32,
  parameter int PAGE_BITS = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             full_wr_i,
  input logic             legacy_wr_i,
  input logic             dir_wr_i,
  input logic             tswitch_i,
  input logic             op_valid_i,
  input logic             op_is_wait_i,
  input logic [31:0]      ctrl_o,
  input logic [DIR_W-1:0] dir_base_o,
  input logic             trap_o,
  input logic             flush_o
);
  // R3: legacy load never clears protection enable nor touches extension type
  assert_pe_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (legacy_wr_i && !full_wr_i && ctrl_o[0]) |=> ctrl_o[0]);
  assert_et_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (legacy_wr_i && !full_wr_i) |=> (ctrl_o[4] == $past(ctrl_o[4])));
  assert_ts_set_R4: assert property (@(posedge clk) disable iff (rst)
    tswitch_i |=> ctrl_o[3]);
  assert_esc_em_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !op_is_wait_i && ctrl_o[2]) |=> trap_o);
  assert_trap_src_R5: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $past(op_valid_i));
  assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_is_wait_i && !(ctrl_o[1] && ctrl_o[3])) |=> !trap_o);
  assert_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
    dir_base_o[PAGE_BITS-1:0] == '0);
  assert_dir_flush_R8: assert property (@(posedge clk) disable iff (rst)
    dir_wr_i |=> flush_o);
  assert_flush_src_R9: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> ($past(dir_wr_i) || $past(tswitch_i)));
endmodule

bind mcr_trap_unit mcr_trap_chk #(.DIR_W(DIR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .full_wr_i    (full_wr_i),
  .legacy_wr_i  (legacy_wr_i),
  .dir_wr_i     (dir_wr_i),
  .tswitch_i    (tswitch_i),
  .op_valid_i   (op_valid_i),
  .op_is_wait_i (op_is_wait_i),
  .ctrl_o       (ctrl_o),
  .dir_base_o   (dir_base_o),
  .trap_o       (trap_o),
  .flush_o      (flush_o)
);

// File: tb/sim_mcr_trap_unit.sv
`timescale 1ns/1ps
module sim_mcr_trap_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_level_i = 1'b0;
  logic        full_wr_i = 1'b0, legacy_wr_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        dir_wr_i = 1'b0;
  logic [31:0] dir_data_i = '0;
  logic        tswitch_i = 1'b0;
  logic [31:0] ts_dir_data_i = '0;
  logic        op_valid_i = 1'b0, op_is_wait_i = 1'b0;
  logic [31:0] ctrl_o, dir_base_o;
  logic        trap_o, flush_o;
  logic [7:0]  trap_vec_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mcr_trap_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    full_wr_i = 0; legacy_wr_i = 0; dir_wr_i = 0; tswitch_i = 0;
    op_valid_i = 0; op_is_wait_i = 0;
  endtask

  task automatic full_load(input logic [31:0] d);
    wr_data_i = d; full_wr_i = 1; step(); idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with error level high, then low
    err_level_i = 1; rst = 1; step(); step(); rst = 0; err_level_i = 0; step();
    chk("R1 ctrl", ctrl_o, 32'h0000_0010);
    chk("R1 dir", dir_base_o, 32'h0);
    chk("R1 trap/flush", {30'd0, trap_o, flush_o}, 32'h0);
    rst = 1; step(); rst = 0; step();
    chk("R1 ctrl et0", ctrl_o, 32'h0);

    // R2
    full_load(32'hFFFF_FFFF);
    chk("R2 all ones", ctrl_o, 32'h8000_001F);
    full_load(32'h0);
    chk("R2 full clears pe", ctrl_o, 32'h0);

    // R3
    full_load(32'h8000_0010);
    wr_data_i = 32'h0000_000F; legacy_wr_i = 1; step(); idle();
    chk("R3 legacy set", ctrl_o, 32'h8000_001F);
    wr_data_i = 32'h0000_0000; legacy_wr_i = 1; step(); idle();
    chk("R3 legacy pe sticky", ctrl_o, 32'h8000_0011);
    wr_data_i = 32'h0000_0000; legacy_wr_i = 1; full_wr_i = 1; step(); idle();
    chk("R3 full wins", ctrl_o, 32'h0);

    // R4 with R9 unchanged directory
    wr_data_i = 32'h0; full_wr_i = 1; tswitch_i = 1; ts_dir_data_i = 32'h0; step(); idle();
    chk("R4 ts forced", ctrl_o, 32'h0000_0008);
    chk("R9 no flush same", {31'd0, flush_o}, 32'h0);

    // R7 R8
    dir_data_i = 32'h1234_5FFF; dir_wr_i = 1; step(); idle();
    chk("R7 low masked", dir_base_o, 32'h1234_5000);
    chk("R8 flush", {31'd0, flush_o}, 32'h1);
    step();
    chk("R8 flush one cycle", {31'd0, flush_o}, 32'h0);
    dir_wr_i = 1; step(); idle();
    chk("R8 flush same value", {31'd0, flush_o}, 32'h1);

    // R9
    tswitch_i = 1; ts_dir_data_i = 32'h1234_5ABC; step(); idle();
    chk("R9 same masked", {31'd0, flush_o}, 32'h0);
    tswitch_i = 1; ts_dir_data_i = 32'h2000_0000; step(); idle();
    chk("R9 differs", {31'd0, flush_o}, 32'h1);
    chk("R9 new base", dir_base_o, 32'h2000_0000);
    tswitch_i = 1; ts_dir_data_i = 32'h3000_0000;
    dir_wr_i = 1; dir_data_i = 32'h4000_0000; step(); idle();
    chk("R9 explicit wins", dir_base_o, 32'h4000_0000);

    // R5 R6 sweep
    for (int f = 0; f < 8; f++) begin
      for (int w = 0; w < 2; w++) begin
        logic em, mp, ts, exp_t;
        em = f[2]; mp = f[1]; ts = f[0];
        full_load({28'd0, ts, em, mp, 1'b0});
        exp_t = w ? (mp & ts) : (em | ts);
        op_valid_i = 1; op_is_wait_i = w[0]; step(); idle();
        if (w) chk("R6 wait trap", {31'd0, trap_o}, {31'd0, exp_t});
        else   chk("R5 escape trap", {31'd0, trap_o}, {31'd0, exp_t});
        chk("R5 vector", {24'd0, trap_vec_o}, exp_t ? 32'd7 : 32'd0);
        step();
        chk("R5 one cycle", {31'd0, trap_o}, 32'h0);
      end
    end

    // R10: trap uses pre-write state
    full_load(32'h0000_0004);
    wr_data_i = 32'h0; full_wr_i = 1; op_valid_i = 1; op_is_wait_i = 0; step(); idle();
    chk("R10 old state traps", {31'd0, trap_o}, 32'h1);
    op_valid_i = 1; step(); idle();
    chk("R10 new state quiet", {31'd0, trap_o}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule